// File: doc/BRIEF.md
# Auto-Baud Pulse Measurement Unit

This block watches a serial receive line and gathers timing statistics from which software can work out the line's bit rate. While its enable input is high, it filters out short disturbances on the line, measures the duration of every clean low and high interval in system clock cycles, and keeps three results. The results are the narrowest low interval, the widest high interval, and the number of accepted level changes. Software typically raises the enable, lets a few characters arrive, reads the three results, and derives a 20-bit integer clock divider from them. That derivation is outside this block.

The line passes through a two-stage synchroniser and then through a glitch filter with a programmable width. A new level only counts once it has held for that many cycles. The filter delays rising and falling changes by the same amount, so the distance between two accepted changes equals the width of the clean pulse between them. A rising edge on the enable restarts the measurement. While the enable is low, the results are frozen.

Top module: `baud_probe`

## Requirements
- R1: After reset, `low_min_o` is all ones, `high_max_o` is zero and `edge_cnt_o` is zero.
- R2: In the cycle after the enable input is seen to rise, `low_min_o` reloads to all ones and `high_max_o` and `edge_cnt_o` clear to zero, whatever they held before.
- R3: While `en_i` is low, activity on `rx_i` has no effect: all three outputs keep their values.
- R4: A new line level that holds for fewer than `glitch_w_i` consecutive synchronised cycles is ignored, and the interval it interrupted continues. A level that holds for exactly `glitch_w_i` cycles is accepted. Values 0 and 1 both accept a single-cycle level.
- R5: `low_min_o` holds the smallest width, in clock cycles, of any low interval that has been closed by an accepted rising change since the measurement restarted.
- R6: `high_max_o` holds the largest width, in clock cycles, of any high interval that has been closed by an accepted falling change since the measurement restarted.
- R7: An interval is compared only when an accepted change closes it and an accepted change after the restart opened it. The level present when the enable rises is never compared, and neither is an interval that is still open.
- R8: `edge_cnt_o` counts every accepted change in either direction and saturates at 2^EDGE_W-1.
- R9: The width counter saturates at 2^CNT_W-1, so an interval longer than that is recorded as 2^CNT_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_i | input | 1 | Asynchronous serial receive line, idle high |
| en_i | input | 1 | Measurement enable; a rising edge restarts the statistics |
| glitch_w_i | input | GLITCH_W | Minimum number of cycles a new level must hold to be accepted |
| low_min_o | output | CNT_W | Narrowest closed low interval, in clock cycles |
| high_max_o | output | CNT_W | Widest closed high interval, in clock cycles |
| edge_cnt_o | output | EDGE_W | Accepted level changes since the last restart |

## Verification
The bench builds the unit with CNT_W = 12 and EDGE_W = 5, and leaves GLITCH_W at 8. The narrower counters let a 5000-cycle high interval drive the width counter into saturation. They also let a train of forty changes reach the edge-count limit, both within a short run. The narrow counters do not change the glitch, closing-edge or restart behaviour. The bench applies those at several filter widths, including 0 and exactly the width of the pulse.

// File: rtl/bprobe_pkg.sv
package bprobe_pkg;

    localparam int CNT_W_DEF    = 20;
    localparam int EDGE_W_DEF   = 10;
    localparam int GLITCH_W_DEF = 8;
    localparam int SYNC_DEPTH   = 2;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } level_e;

    // One accepted line change, with the level of the interval it closes
    typedef struct packed {
        logic   fire;
        level_e closed;
    } edge_evt_t;

    localparam edge_evt_t EVT_NONE = '{fire: 1'b0, closed: LVL_HIGH};

endpackage

// File: rtl/bprobe_sync.sv
module bprobe_sync #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [DEPTH-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[DEPTH-2:0], d_i};
        end
    end

    assign q_o = chain_q[DEPTH-1];
endmodule

// File: rtl/bprobe_filter.sv
module bprobe_filter
    import bprobe_pkg::*;
#(
    parameter int GW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          arm_i,
    input  logic          rx_s_i,
    input  logic [GW-1:0] gw_i,
    output edge_evt_t     evt_o
);
    logic          lvl_q;
    logic [GW-1:0] dev_q;
    logic [GW:0]   run_nx;
    logic          differ;
    logic          take;

    assign differ = (rx_s_i != lvl_q);
    assign run_nx = {1'b0, dev_q} + 1'b1;
    assign take   = differ && (run_nx >= {1'b0, gw_i});

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= 1'b1;
            dev_q <= '0;
            evt_o <= EVT_NONE;
        end else if (!arm_i) begin
            lvl_q <= rx_s_i;
            dev_q <= '0;
            evt_o <= EVT_NONE;
        end else begin
            evt_o.fire   <= take;
            evt_o.closed <= level_e'(lvl_q);
            if (!differ) begin
                dev_q <= '0;
            end else if (take) begin
                lvl_q <= ~lvl_q;
                dev_q <= '0;
            end else begin
                dev_q <= run_nx[GW-1:0];
            end
        end
    end
endmodule

// File: rtl/bprobe_track.sv
module bprobe_track
    import bprobe_pkg::*;
#(
    parameter int CW = 20,
    parameter int EW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          run_i,
    input  edge_evt_t     evt_i,
    output logic [CW-1:0] low_min_o,
    output logic [CW-1:0] high_max_o,
    output logic [EW-1:0] edge_cnt_o
);
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};
    localparam logic [EW-1:0] EMAX = {EW{1'b1}};

    logic [CW-1:0] width_q;
    logic [CW-1:0] width_inc;
    logic          open_q;

    assign width_inc = (width_q == CMAX) ? width_q : width_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || start_i) begin
            width_q    <= '0;
            open_q     <= 1'b0;
            low_min_o  <= CMAX;
            high_max_o <= '0;
            edge_cnt_o <= '0;
        end else if (run_i) begin
            if (evt_i.fire) begin
                width_q <= {{(CW-1){1'b0}}, 1'b1};
                open_q  <= 1'b1;
                if (edge_cnt_o != EMAX) begin
                    edge_cnt_o <= edge_cnt_o + 1'b1;
                end
                if (open_q) begin
                    if (evt_i.closed == LVL_LOW && width_q < low_min_o) begin
                        low_min_o <= width_q;
                    end
                    if (evt_i.closed == LVL_HIGH && width_q > high_max_o) begin
                        high_max_o <= width_q;
                    end
                end
            end else begin
                width_q <= width_inc;
            end
        end
    end
endmodule

// File: rtl/baud_probe.sv
module baud_probe
    import bprobe_pkg::*;
#(
    parameter int CNT_W    = CNT_W_DEF,
    parameter int EDGE_W   = EDGE_W_DEF,
    parameter int GLITCH_W = GLITCH_W_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rx_i,
    input  logic                en_i,
    input  logic [GLITCH_W-1:0] glitch_w_i,
    output logic [CNT_W-1:0]    low_min_o,
    output logic [CNT_W-1:0]    high_max_o,
    output logic [EDGE_W-1:0]   edge_cnt_o
);
    logic      en_d;
    logic      start;
    logic      rx_s;
    edge_evt_t evt;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_d <= 1'b0;
        end else begin
            en_d <= en_i;
        end
    end

    assign start = en_i & ~en_d;

    bprobe_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (rx_i),
        .q_o (rx_s)
    );

    bprobe_filter #(.GW(GLITCH_W)) u_filt (
        .clk    (clk),
        .rst    (rst),
        .arm_i  (en_i & ~start),
        .rx_s_i (rx_s),
        .gw_i   (glitch_w_i),
        .evt_o  (evt)
    );

    bprobe_track #(.CW(CNT_W), .EW(EDGE_W)) u_track (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start),
        .run_i      (en_i),
        .evt_i      (evt),
        .low_min_o  (low_min_o),
        .high_max_o (high_max_o),
        .edge_cnt_o (edge_cnt_o)
    );
endmodule

// File: rtl/baud_probe_chk.sv
module baud_probe_chk #(
    parameter int CNT_W  = 20,
    parameter int EDGE_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              en_i,
    input logic [CNT_W-1:0]  low_min_o,
    input logic [CNT_W-1:0]  high_max_o,
    input logic [EDGE_W-1:0] edge_cnt_o
);
    // R2
    restart_init_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(en_i) |=> (low_min_o == {CNT_W{1'b1}}) && (high_max_o == '0) && (edge_cnt_o == '0));

    // R3
    frozen_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> $stable(low_min_o) && $stable(high_max_o) && $stable(edge_cnt_o));

    // R5
    min_never_rises_chk: assert property (@(posedge clk) disable iff (rst)
        (en_i && $past(en_i) && $past(en_i, 2)) |-> (low_min_o <= $past(low_min_o)));

    // R6
    max_never_falls_chk: assert property (@(posedge clk) disable iff (rst)
        (en_i && $past(en_i) && $past(en_i, 2)) |-> (high_max_o >= $past(high_max_o)));

    // R8
    edge_step_chk: assert property (@(posedge clk) disable iff (rst)
        (en_i && $past(en_i) && $past(en_i, 2)) |->
            ((edge_cnt_o == $past(edge_cnt_o)) ||
             ({1'b0, edge_cnt_o} == {1'b0, $past(edge_cnt_o)} + 1'b1)));
endmodule

bind baud_probe baud_probe_chk #(.CNT_W(CNT_W), .EDGE_W(EDGE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .en_i       (en_i),
    .low_min_o  (low_min_o),
    .high_max_o (high_max_o),
    .edge_cnt_o (edge_cnt_o)
);

// File: tb/baud_probe_test.sv
`timescale 1ns/1ps
module baud_probe_test;
    localparam int CW = 12;
    localparam int EW = 5;
    localparam int GW = 8;
    localparam longint CMAX = (64'd1 << CW) - 1;
    localparam longint EMAX = (64'd1 << EW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rx = 1'b1;
    logic          en = 1'b0;
    logic [GW-1:0] gw = '0;
    logic [CW-1:0] low_min;
    logic [CW-1:0] high_max;
    logic [EW-1:0] edge_cnt;

    always #2.5 clk = ~clk;

    baud_probe #(.CNT_W(CW), .EDGE_W(EW), .GLITCH_W(GW)) uut (
        .clk        (clk),
        .rst        (rst),
        .rx_i       (rx),
        .en_i       (en),
        .glitch_w_i (gw),
        .low_min_o  (low_min),
        .high_max_o (high_max),
        .edge_cnt_o (edge_cnt)
    );

    typedef struct {
        longint mn;
        longint mx;
        longint ec;
        string  tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;
    int   pw[64];
    int   np = 0;

    task automatic cmp(input string what, input string tag, input longint act, input longint expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    // Monitor: pops expected items and compares them against the outputs
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                cmp("low_min",  e.tag, longint'(low_min),  e.mn);
                cmp("high_max", e.tag, longint'(high_max), e.mx);
                cmp("edge_cnt", e.tag, longint'(edge_cnt), e.ec);
            end
        end
    end

    task automatic push_exp(input longint mn, input longint mx, input longint ec, input string tag);
        exp_t e;
        e.mn = mn; e.mx = mx; e.ec = ec; e.tag = tag;
        exp_q.push_back(e);
        while (exp_q.size() > 0) @(negedge clk);
    endtask

    task automatic clear_pat();
        np = 0;
    endtask

    task automatic add(input int w);
        pw[np] = w;
        np++;
    endtask

    // Drives the pulse list, alternating low/high, from an idle-high line
    task automatic drive(input int g, input bit restart);
        @(negedge clk);
        if (restart) begin
            en = 1'b0;
            repeat (3) @(negedge clk);
            gw = GW'(g);
            en = 1'b1;
            repeat (60) @(negedge clk);
        end else begin
            gw = GW'(g);
        end
        for (int i = 0; i < np; i++) begin
            rx = (i % 2 == 0) ? 1'b0 : 1'b1;
            repeat (pw[i]) @(negedge clk);
        end
        rx = 1'b1;
        repeat (20) @(negedge clk);
    endtask

    function automatic longint sat(input longint w);
        return (w > CMAX) ? CMAX : w;
    endfunction

    // Expected results for a pattern in which every pulse clears the filter
    task automatic push_auto(input string tag);
        longint mn = CMAX;
        longint mx = 0;
        longint ec;
        for (int i = 0; i < np; i++) begin
            if (i % 2 == 0) begin
                if (sat(pw[i]) < mn) mn = sat(pw[i]);
            end else if (i < np - 1) begin
                if (sat(pw[i]) > mx) mx = sat(pw[i]);
            end
        end
        ec = (np % 2 == 1) ? np + 1 : np;
        if (ec > EMAX) ec = EMAX;
        push_exp(mn, mx, ec, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        // R1: reset values
        push_exp(CMAX, 0, 0, "R1");

        // R5 R6 R7 R8: clean pattern; idle high before the first edge is not compared
        clear_pat(); add(10); add(30); add(8); add(20); add(12);
        drive(2, 1'b1);
        push_auto("R5 R6 R7 R8");

        // R4: a 3-cycle high inside a low is dropped with width 4, low merges to 23
        clear_pat(); add(10); add(3); add(10); add(40); add(30);
        drive(4, 1'b1);
        push_exp(23, 40, 4, "R4");

        // R4 R7: pulse of exactly the filter width is accepted; open high not compared
        clear_pat(); add(4); add(4); add(3);
        drive(4, 1'b1);
        push_exp(4, 0, 2, "R4 R7");

        // R9: long high saturates the width counter
        clear_pat(); add(5); add(5000); add(7);
        drive(1, 1'b1);
        push_auto("R9");

        // R4: filter width 0 accepts single-cycle pulses
        clear_pat(); add(1); add(2); add(1); add(3);
        drive(0, 1'b1);
        push_exp(1, 2, 4, "R4");

        // R8: forty changes saturate the edge counter
        clear_pat();
        for (int i = 0; i < 40; i++) add(3);
        drive(1, 1'b1);
        push_auto("R8");

        // R3: disabled, line activity leaves results untouched
        @(negedge clk);
        en = 1'b0;
        clear_pat(); add(2); add(2); add(2); add(50);
        drive(1, 1'b0);
        push_exp(3, 3, EMAX, "R3");

        // R2: enable rise restarts the statistics
        en = 1'b1;
        repeat (10) @(negedge clk);
        push_exp(CMAX, 0, 0, "R2");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule